// File: doc/BRIEF.md
# Page-Mode Static Memory Read Controller

This controller turns single read requests from an internal bus into strobe sequences for an asynchronous memory that serves whole pages. Examples are burst flash and page ROM. Each request carries a chip-select index, a byte address and a byte-enable mask. The controller drives one active-low select per device, a read strobe, the data-unit address and active-low byte selects. It returns the sampled data with a one-cycle done pulse.

The controller remembers the device and the upper address bits of the last access, and it keeps that device selected while idle. The first access to a page is timed with a long programmed length. Any later access that lands in the same page is timed with a short programmed length, whatever its offset. A change of device, a pulse reporting an access to some other device, or turning page mode off closes the page. The next access is then slow again.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset all selects, the read strobe and all byte selects are high, `rsp_valid` is low and `req_ready` is high.
- R2: A page miss holds the read strobe low for `cfg_long_len` cycles. Data is sampled on the edge that ends the strobe. `rsp_valid` is high for exactly the one following cycle, carrying that data.
- R3: An access counts as a page hit when page mode is on, a page is open, the chip-select index equals the previous one and the unit-address bits above the page offset are equal. A hit holds the strobe low for `cfg_short_len` cycles. This holds for any offset order, and even when the long length is smaller than the short length.
- R4: `cfg_page_sz` selects 4, 8, 16 or 32 data units per page for codes 0, 1, 2 and 3. The low `cfg_page_sz+2` bits of the unit address are left out of the hit comparison.
- R5: A request to a different chip-select index than the previous one is a page miss.
- R6: A one-cycle `oth_acc` pulse in an idle cycle with no accepted request closes the page. From the next cycle all selects are high, and the next access is a miss.
- R7: While the strobe is low, `mem_bs_n` equals the inverse of the request's `req_be`. Otherwise `mem_bs_n` is all ones.
- R8: With page mode on, `mem_wait` has no effect on access length. With page mode off, each edge that samples `mem_wait` high during an access adds one strobe cycle.
- R9: While page mode is off, no page is kept open and every access takes the long length. The first access after page mode is turned back on is a miss.
- R10: A programmed length of 0 behaves as a length of 1.
- R11: With page mode on, the select line of the open page stays low between accesses. The read strobe is high while idle. At most one select is low at any time.
- R12: `mem_addr` carries the byte address shifted right by log2 of the bytes per data unit, and it holds that value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 1 | Page mode enable |
| cfg_page_sz | input | 2 | Page size code (4/8/16/32 units) |
| cfg_long_len | input | CNT_W | Strobe length of a page miss |
| cfg_short_len | input | CNT_W | Strobe length of a page hit |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Controller idle, request accepted |
| req_cs | input | CSI_W | Chip-select index |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte-enable mask |
| oth_acc | input | 1 | Pulse: an access to another device took place |
| mem_cs_n | output | CS_N | Active-low device selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_addr | output | ADDR_W-log2(DATA_W/8) | Data-unit address |
| mem_bs_n | output | DATA_W/8 | Active-low byte selects |
| mem_wait | input | 1 | Wait from memory, honoured only outside page mode |
| mem_rdata | input | DATA_W | Read data from memory |
| rsp_valid | output | 1 | Done pulse |
| rsp_data | output | DATA_W | Sampled read data |

## Verification
A stale or wrongly cleared page-open flag shows up on the very next request. The read strobe stays low for the long length where the short one was expected, or the reverse. A select line that should idle high stays low, visible within one cycle after an `oth_acc` pulse. A wrong offset mask shows only at page boundaries, so each page size is swept with offsets at both ends of the page and with a step into the adjacent page. A counter or sampling fault moves the done pulse or changes the returned word on the same access.

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CS_N   = 4,
  parameter int CNT_W  = 4,
  localparam int CSI_W   = (CS_N > 1) ? $clog2(CS_N) : 1,
  localparam int BS_W    = DATA_W / 8,
  localparam int UNIT_SH = (BS_W > 1) ? $clog2(BS_W) : 0,
  localparam int UA_W    = ADDR_W - UNIT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_page_sz,
  input  logic [CNT_W-1:0]  cfg_long_len,
  input  logic [CNT_W-1:0]  cfg_short_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSI_W-1:0]  req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BS_W-1:0]   req_be,
  input  logic              oth_acc,
  output logic [CS_N-1:0]   mem_cs_n,
  output logic              mem_rd_n,
  output logic [UA_W-1:0]   mem_addr,
  output logic [BS_W-1:0]   mem_bs_n,
  input  logic              mem_wait,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CSI_W-1:0] cur_cs, last_cs;
  logic [UA_W-1:0]  ua_q, last_ua;
  logic [BS_W-1:0]  be_q;
  logic             pg_valid;

  logic [UA_W-1:0]  ua_in, up_mask;
  logic [CNT_W-1:0] len_sel, len_ld;
  logic             page_hit, accept, stall;

  assign ua_in    = req_addr[ADDR_W-1:UNIT_SH];
  assign up_mask  = {UA_W{1'b1}} << (32'(cfg_page_sz) + 2);
  assign page_hit = cfg_page_en && pg_valid && (req_cs == last_cs)
                    && (((ua_in ^ last_ua) & up_mask) == '0);
  assign len_sel  = page_hit ? cfg_short_len : cfg_long_len;
  assign len_ld   = (len_sel == '0) ? CNT_W'(1) : len_sel;
  assign accept   = req_valid && !busy;
  assign stall    = !cfg_page_en && mem_wait;
  assign req_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cur_cs    <= '0;
      ua_q      <= '0;
      be_q      <= '0;
      pg_valid  <= 1'b0;
      last_cs   <= '0;
      last_ua   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= len_ld;
        cur_cs <= req_cs;
        ua_q   <= ua_in;
        be_q   <= req_be;
        if (cfg_page_en) begin
          pg_valid <= 1'b1;
          last_cs  <= req_cs;
          last_ua  <= ua_in;
        end
      end else if (busy && !stall) begin
        if (cnt == CNT_W'(1)) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= mem_rdata;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (!cfg_page_en || (oth_acc && !accept))
        pg_valid <= 1'b0;
    end
  end

  logic             cs_on;
  logic [CSI_W-1:0] cs_idx;
  assign cs_on    = busy || (cfg_page_en && pg_valid);
  assign cs_idx   = busy ? cur_cs : last_cs;
  assign mem_cs_n = cs_on ? ~(CS_N'(1) << cs_idx) : '1;
  assign mem_rd_n = !busy;
  assign mem_bs_n = busy ? ~be_q : '1;
  assign mem_addr = ua_q;

  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (mem_cs_n != '1));
  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_rd_n));
  p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_wait_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_page_en && cnt != CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));
  p_bs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_n |-> (mem_bs_n == '1));
  p_page_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_page_en |=> !pg_valid);

endmodule

// File: tb/sim_pgrd_ctrl.sv
module sim_pgrd_ctrl;
  localparam int CLK_PER = 10;
  localparam int ADDR_W = 16, DATA_W = 16, CS_N = 4, CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_page_en = 0;
  logic [1:0] cfg_page_sz = 0;
  logic [CNT_W-1:0] cfg_long_len = 4, cfg_short_len = 2;
  logic req_valid = 0, oth_acc = 0, mem_wait = 0;
  logic req_ready, mem_rd_n, rsp_valid;
  logic [1:0] req_cs = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [1:0] req_be = 0, mem_bs_n;
  logic [CS_N-1:0] mem_cs_n;
  logic [ADDR_W-2:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata, rsp_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit bvalid = 0;
  int bcs = 0, bpage = 0;

  always #(CLK_PER/2) clk = ~clk;

  assign mem_rdata = (16'(mem_addr) * 16'd3) ^ 16'hC35A ^ {~mem_cs_n, 12'h000};

  pgrd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .CNT_W(CNT_W)) u0 (
    .clk, .rst_n, .cfg_page_en, .cfg_page_sz, .cfg_long_len, .cfg_short_len,
    .req_valid, .req_ready, .req_cs, .req_addr, .req_be, .oth_acc,
    .mem_cs_n, .mem_rd_n, .mem_addr, .mem_bs_n, .mem_wait, .mem_rdata,
    .rsp_valid, .rsp_data);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic rd(input int cs, input int addr, input int be, input int w);
    int ua = addr >> 1;
    bit hit = cfg_page_en && bvalid && (cs == bcs) && ((ua >> (cfg_page_sz + 2)) == bpage);
    int exp_len = hit ? eff(int'(cfg_short_len)) : eff(int'(cfg_long_len));
    int lat = 0;
    bit bs_ok = 1, a_ok = 1;
    logic [15:0] exp_d;
    if (!cfg_page_en) exp_len += w;
    req_valid = 1; req_cs = 2'(cs); req_addr = 16'(addr); req_be = 2'(be); mem_wait = 0;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; !rsp_valid && i < 200; i++) begin
      mem_wait = (i < w);
      if (!mem_rd_n) begin
        lat++;
        if (mem_bs_n != ~2'(be)) bs_ok = 0;
        if (int'(mem_addr) != ua) a_ok = 0;
      end
      @(negedge clk);
    end
    mem_wait = 0;
    exp_d = (16'(ua) * 16'd3) ^ 16'hC35A ^ {4'(1 << cs), 12'h000};
    chk(lat == exp_len, hit ? "R3 hit length" : "R2 miss length", lat, exp_len);
    chk(rsp_data == exp_d && rsp_valid, "R2 data", int'(rsp_data), int'(exp_d));
    chk(bs_ok, "R7 byte selects", int'(mem_bs_n), be);
    chk(a_ok, "R12 unit address", int'(mem_addr), ua);
    @(negedge clk);
    chk(!rsp_valid && mem_rd_n, "R2 single done pulse", int'(rsp_valid), 0);
    if (cfg_page_en) begin
      chk(mem_cs_n == ~4'(1 << cs), "R11 select held", int'(mem_cs_n), int'(~4'(1 << cs)));
      bvalid = 1; bcs = cs; bpage = ua >> (cfg_page_sz + 2);
    end else begin
      chk(mem_cs_n == 4'hF, "R9 select released", int'(mem_cs_n), 15);
    end
  endtask

  task automatic other();
    oth_acc = 1;
    @(negedge clk);
    oth_acc = 0;
    bvalid = 0;
    chk(mem_cs_n == 4'hF, "R6 page closed", int'(mem_cs_n), 15);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int longs[3] = '{6, 2, 0};
    int shorts[3] = '{2, 5, 3};
    #1;
    chk(mem_cs_n == 4'hF && mem_rd_n && mem_bs_n == 2'b11, "R1 reset outputs", int'(mem_cs_n), 15);
    chk(!rsp_valid && req_ready, "R1 reset handshake", int'(rsp_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_page_en = 1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int p = 0; p < 3; p++) begin
        int units = 4 << sz;
        int base = 16'h0400 + (p * 3 + sz) * 128;
        cfg_page_sz = 2'(sz); cfg_long_len = 4'(longs[p]); cfg_short_len = 4'(shorts[p]);
        @(negedge clk);
        rd(1, base + 2, 2'b11, 0);                   // R2 opens page (R10 when long is 0)
        rd(1, base + 6, 2'b01, 0);                   // R3 non-sequential hit
        rd(1, base + 2 * (units - 1) + 1, 2'b10, 2); // R4 last unit, R8 wait ignored
        rd(1, base, 2'b11, 0);                       // R3 backwards hit
        rd(1, base + 2 * units, 2'b11, 0);           // R4 next page misses
        rd(2, base + 2 * units, 2'b01, 0);           // R5 select change
        rd(2, base + 2 * units + 2, 2'b11, 0);       // R3 hit on new device
        other();                                     // R6
        rd(2, base + 2 * units + 2, 2'b11, 0);       // R6 miss after other access
      end
    end
    cfg_long_len = 4'd3; cfg_short_len = 4'd1; cfg_page_sz = 2'd1;
    cfg_page_en = 0; bvalid = 0;
    @(negedge clk);
    chk(mem_cs_n == 4'hF, "R9 select released on disable", int'(mem_cs_n), 15);
    rd(0, 16'h0200, 2'b11, 0);                       // R9 long in plain mode
    rd(0, 16'h0202, 2'b01, 3);                       // R8 wait stretches
    rd(3, 16'h0204, 2'b10, 1);                       // R8
    cfg_page_en = 1;
    @(negedge clk);
    rd(0, 16'h0202, 2'b11, 0);                       // R9 first access after enable misses
    rd(0, 16'h0204, 2'b11, 0);                       // R3
    finished = 1;
    summary();
  end
endmodule